// File: doc/BRIEF.md
# I2C Bit Engine with Clock-Stretch Timeout

This block is the bit layer under an I2C controller. It takes one command at a time: START, STOP, write one bit or read one bit. A START issued while a transfer is already open becomes a repeated START. The block works on open-drain lines, so its outputs are only pull-low enables for SCL and SDA. It reads the real line levels back through two-flop synchronizers.

All timing is counted in units of `UNIT_CYCLES` clocks. Each time the engine releases SCL, it lets a target hold the clock low, checking SCL once per unit. If SCL is still low after `STRETCH_LIMIT` checks, the engine ends the transfer with a STOP of its own and reports a timeout. It also detects lost arbitration on written 1 bits and on repeated START. It keeps a started flag, so it can tell an opening START from a repeated one and knows when a STOP has nothing to close.

Each command finishes with a one-cycle `done_o` pulse, a read bit and a two-bit result code. A byte layer above this block builds bytes and decides on retries.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, both pull-low outputs are off, `started_o`, `done_o`, `busy_o` and `err_o` are 0.
- R2: START while not started, with both lines high, pulls SDA low. One unit later it pulls SCL low, sets `started_o` and returns code 2'b00.
- R3: START while not started, with SCL or SDA low, returns code 2'b10. It pulls neither line low and leaves `started_o` at 0.
- R4: Write-bit drives SDA low exactly when the bit is 0 for the whole time SCL is released. It then pulls SCL low and returns 2'b00 when no arbitration loss occurs.
- R5: Read-bit releases SDA. It returns in `rd_bit_o` the SDA level sampled one unit after SCL is seen high, then pulls SCL low.
- R6: A written 1 that reads back as SDA low while SCL is high returns code 2'b10. It clears `started_o` and leaves both lines released.
- R7: START while started releases SDA, then SCL, and waits out stretching. If SDA then reads high, it continues as a fresh START ending with both lines low and `started_o` set. If SDA reads low, it returns 2'b10 and clears `started_o`.
- R8: After SCL is released, the command does not complete until the target has let SCL go high.
- R9: If SCL stays low for `STRETCH_LIMIT` checks, the engine performs a STOP, returns 2'b01, clears `started_o` and leaves both lines released.
- R10: STOP while started pulls SDA low and releases SCL. After SCL is high it releases SDA, so SDA rises once while SCL is high. It then clears `started_o` and returns 2'b00.
- R11: STOP while not started completes on the next cycle with code 2'b00 and touches neither line.
- R12: Commands are encoded 2'b00 START, 2'b01 STOP, 2'b10 write-bit, 2'b11 read-bit. They are taken only while `busy_o` is low, and each gives exactly one single-cycle `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request, taken when `busy_o` is low |
| cmd_i | input | 2 | Command code |
| wr_bit_i | input | 1 | Bit to send for write-bit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Command in progress, or done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rd_bit_o | output | 1 | Bit captured by the last read-bit |
| err_o | output | 2 | Result code: 00 ok, 01 timeout, 10 arbitration lost |
| started_o | output | 1 | A transfer is open |

## Verification
The clock-stretch check and the timeout expiry can fall on the same per-unit check, when the target lets SCL go on the final allowed check. The design gives priority to SCL being high. The bench provokes this by holding SCL low for a write-bit, sweeping the hold length one clock at a time across the limit. Short holds must return 2'b00 and long holds 2'b01, no other code may appear, and once a timeout is seen every longer hold must also time out.

// File: rtl/i2c_be_pkg.sv
package i2c_be_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'b00,
    CMD_STOP  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_READ  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_TIMEOUT = 2'b01,
    ERR_ARB     = 2'b10
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRETCH,
    ST_HOLD,
    ST_START_A,
    ST_STOP_A,
    ST_STOP_C
  } state_e;
endpackage

// File: rtl/i2c_be_sync.sv
module i2c_be_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_be_unit_timer.sv
module i2c_be_unit_timer #(
  parameter int UNIT_CYCLES = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = $clog2(UNIT_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= RELOAD;
    else if (restart_i || cnt_q == '0)    cnt_q <= RELOAD;
    else                                  cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0) && !restart_i;

  unit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD);
endmodule

// File: rtl/i2c_be_poll_cnt.sv
module i2c_be_poll_cnt #(
  parameter int LIMIT = 7000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic poll_low_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] MAXV = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i)                     cnt_q <= '0;
    else if (poll_low_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = poll_low_i && (cnt_q == LAST);

  // R9
  poll_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAXV);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_be_pkg::*;
#(
  parameter int UNIT_CYCLES   = 250,
  parameter int STRETCH_LIMIT = 7000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       wr_bit_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_bit_o,
  output logic [1:0] err_o,
  output logic       started_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_sync;
  logic scl_s, sda_s;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_be_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_sync[g])
    );
  end

  assign scl_s = line_sync[1];
  assign sda_s = line_sync[0];

  state_e state_q;
  cmd_e   op_q;
  err_e   pend_q, err_q;
  logic   bit_q, started_q, scl_lo_q, sda_lo_q, done_q, rd_q, restart_q;
  logic   tick, expired, poll_low, accept;

  i2c_be_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart_q),
    .tick_o   (tick)
  );

  assign poll_low = tick && (state_q == ST_STRETCH) && !scl_s;

  i2c_be_poll_cnt #(.LIMIT(STRETCH_LIMIT)) u_poll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q != ST_STRETCH),
    .poll_low_i(poll_low),
    .expired_o (expired)
  );

  assign busy_o = (state_q != ST_IDLE) || done_q;
  assign accept = cmd_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= CMD_START;
      pend_q    <= ERR_NONE;
      err_q     <= ERR_NONE;
      bit_q     <= 1'b0;
      started_q <= 1'b0;
      scl_lo_q  <= 1'b0;
      sda_lo_q  <= 1'b0;
      done_q    <= 1'b0;
      rd_q      <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      restart_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= cmd_e'(cmd_i);
            bit_q  <= wr_bit_i;
            pend_q <= ERR_NONE;
            unique case (cmd_e'(cmd_i))
              CMD_START: begin
                if (started_q) begin
                  sda_lo_q  <= 1'b0;
                  state_q   <= ST_SETUP;
                  restart_q <= 1'b1;
                end else if (!scl_s || !sda_s) begin
                  err_q  <= ERR_ARB;
                  done_q <= 1'b1;
                end else begin
                  sda_lo_q  <= 1'b1;
                  state_q   <= ST_START_A;
                  restart_q <= 1'b1;
                end
              end
              CMD_STOP: begin
                if (!started_q) begin
                  err_q  <= ERR_NONE;
                  done_q <= 1'b1;
                end else begin
                  sda_lo_q  <= 1'b1;
                  state_q   <= ST_STOP_A;
                  restart_q <= 1'b1;
                end
              end
              CMD_WRITE: begin
                sda_lo_q  <= !wr_bit_i;
                state_q   <= ST_SETUP;
                restart_q <= 1'b1;
              end
              default: begin
                sda_lo_q  <= 1'b0;
                state_q   <= ST_SETUP;
                restart_q <= 1'b1;
              end
            endcase
          end
        end
        ST_SETUP: begin
          if (tick) begin
            scl_lo_q  <= 1'b0;
            state_q   <= ST_STRETCH;
            restart_q <= 1'b1;
          end
        end
        ST_STRETCH: begin
          // SCL seen high wins over expiry on the same poll
          if (tick && scl_s) begin
            state_q   <= ST_HOLD;
            restart_q <= 1'b1;
          end else if (expired) begin
            if (op_q == CMD_STOP) begin
              state_q   <= ST_HOLD;
              restart_q <= 1'b1;
            end else begin
              pend_q    <= ERR_TIMEOUT;
              op_q      <= CMD_STOP;
              sda_lo_q  <= 1'b1;
              state_q   <= ST_STOP_A;
              restart_q <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (tick) begin
            unique case (op_q)
              CMD_WRITE: begin
                if (bit_q && !sda_s) begin
                  started_q <= 1'b0;
                  err_q     <= ERR_ARB;
                end else begin
                  scl_lo_q  <= 1'b1;
                  err_q     <= ERR_NONE;
                end
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
              CMD_READ: begin
                rd_q     <= sda_s;
                scl_lo_q <= 1'b1;
                err_q    <= ERR_NONE;
                done_q   <= 1'b1;
                state_q  <= ST_IDLE;
              end
              CMD_START: begin
                if (!sda_s) begin
                  started_q <= 1'b0;
                  err_q     <= ERR_ARB;
                  done_q    <= 1'b1;
                  state_q   <= ST_IDLE;
                end else begin
                  sda_lo_q  <= 1'b1;
                  state_q   <= ST_START_A;
                  restart_q <= 1'b1;
                end
              end
              default: begin
                sda_lo_q  <= 1'b0;
                state_q   <= ST_STOP_C;
                restart_q <= 1'b1;
              end
            endcase
          end
        end
        ST_START_A: begin
          if (tick) begin
            scl_lo_q  <= 1'b1;
            started_q <= 1'b1;
            err_q     <= ERR_NONE;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_STOP_A: begin
          if (tick) begin
            scl_lo_q  <= 1'b0;
            state_q   <= ST_STRETCH;
            restart_q <= 1'b1;
          end
        end
        ST_STOP_C: begin
          if (tick) begin
            started_q <= 1'b0;
            err_q     <= pend_q;
            done_q    <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_low_o = scl_lo_q;
  assign sda_low_o = sda_lo_q;
  assign done_o    = done_q;
  assign rd_bit_o  = rd_q;
  assign err_o     = err_q;
  assign started_o = started_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  start_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_o) |-> (scl_low_o && sda_low_o));
  // R6
  arb_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'b10) |-> (!started_o && !scl_low_o && !sda_low_o));
  // R9
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == 2'b01) |-> (!started_o && !scl_low_o && !sda_low_o));
  // R11
  idle_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_i == 2'b01 && !started_o) |=> (done_o && err_o == 2'b00 &&
      $stable(scl_low_o) && $stable(sda_low_o)));
endmodule

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;
  localparam int UNIT  = 4;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic wr_bit = 1'b0;
  logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
  logic scl_low, sda_low, busy, done, rd_bit, started;
  logic [1:0] err;
  logic scl_line, sda_line;

  int checks = 0, fails = 0, cyc = 0;
  int wr_viol = 0, stop_rises = 0, stop_bad = 0;
  logic wr_active = 1'b0, stop_active = 1'b0, wr_cur = 1'b0, prev_sda = 1'b1;

  assign scl_line = !(scl_low || tgt_scl_low);
  assign sda_line = !(sda_low || tgt_sda_low);

  always #10 clk = ~clk;

  i2c_bit_engine #(.UNIT_CYCLES(UNIT), .STRETCH_LIMIT(LIMIT), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .wr_bit_i(wr_bit),
    .scl_i(scl_line), .sda_i(sda_line), .scl_low_o(scl_low), .sda_low_o(sda_low),
    .busy_o(busy), .done_o(done), .rd_bit_o(rd_bit), .err_o(err), .started_o(started)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_sda <= sda_line;
    if (stop_active && sda_line && !prev_sda) begin
      stop_rises <= stop_rises + 1;
      if (!scl_line) stop_bad <= stop_bad + 1;
    end
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk)
    if (wr_active && !scl_low && (sda_low != !wr_cur)) wr_viol++;

  task automatic do_cmd(input logic [1:0] c, input logic b, output logic [1:0] e,
                        output logic r, output int t_done);
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd = c; wr_bit = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R12 no done", 0, 1);
    e = err; r = rd_bit; t_done = cyc;
    @(negedge clk);
    // R12: single-cycle pulse
    chk(!done, "R12 pulse", int'(done), 0);
  endtask

  initial begin
    logic [1:0] e;
    logic r;
    int t, t_rel;
    bit seen_to;
    repeat (3) @(negedge clk);
    // R1
    chk(!scl_low && !sda_low && !started && !done && !busy && err == 2'b00, "R1 reset",
        {scl_low, sda_low, started, done, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11
    do_cmd(2'b01, 1'b0, e, r, t);
    chk(e == 2'b00 && !scl_low && !sda_low && !started, "R11 idle stop", e, 0);

    // R3: bus busy on SDA, then on SCL
    tgt_sda_low = 1'b1; repeat (4) @(negedge clk);
    do_cmd(2'b00, 1'b0, e, r, t);
    chk(e == 2'b10 && !started && !scl_low && !sda_low, "R3 sda busy", e, 2);
    tgt_sda_low = 1'b0; tgt_scl_low = 1'b1; repeat (4) @(negedge clk);
    do_cmd(2'b00, 1'b0, e, r, t);
    chk(e == 2'b10 && !started && !scl_low && !sda_low, "R3 scl busy", e, 2);
    tgt_scl_low = 1'b0; repeat (4) @(negedge clk);

    // R2
    do_cmd(2'b00, 1'b0, e, r, t);
    chk(e == 2'b00 && started && scl_low && sda_low, "R2 start", {e, started, scl_low, sda_low}, 7);

    // R4: every byte value, MSB first
    for (int v = 0; v < 256; v++) begin
      for (int i = 7; i >= 0; i--) begin
        wr_cur = v[i]; wr_viol = 0; wr_active = 1'b1;
        do_cmd(2'b10, v[i], e, r, t);
        wr_active = 1'b0;
        chk(e == 2'b00 && scl_low && (sda_low == !v[i]) && wr_viol == 0 && started,
            "R4 write", {e, wr_viol[3:0]}, 0);
      end
    end

    // R5: target drives a computed bit pattern
    for (int i = 0; i < 256; i++) begin
      logic exp_b;
      exp_b = logic'(i[0] ^ i[3] ^ i[6]);
      tgt_sda_low = !exp_b;
      do_cmd(2'b11, 1'b0, e, r, t);
      chk(r == exp_b && e == 2'b00 && scl_low && !sda_low, "R5 read", int'(r), int'(exp_b));
    end
    tgt_sda_low = 1'b0;

    // R7: repeated START, clean
    do_cmd(2'b00, 1'b0, e, r, t);
    chk(e == 2'b00 && started && scl_low && sda_low, "R7 rstart ok", e, 0);

    // R8: stretch of 5 units during a write
    tgt_scl_low = 1'b1;
    fork begin repeat (5 * UNIT) @(negedge clk); t_rel = cyc; tgt_scl_low = 1'b0; end join_none
    do_cmd(2'b10, 1'b1, e, r, t);
    chk(e == 2'b00 && t > t_rel + 2, "R8 stretch", t, t_rel);

    // R10
    stop_rises = 0; stop_bad = 0; stop_active = 1'b1;
    do_cmd(2'b01, 1'b0, e, r, t);
    stop_active = 1'b0;
    chk(e == 2'b00 && !started && !scl_low && !sda_low && stop_rises == 1 && stop_bad == 0,
        "R10 stop", stop_rises * 10 + stop_bad, 10);

    // R7: repeated START loses arbitration
    do_cmd(2'b00, 1'b0, e, r, t);
    tgt_sda_low = 1'b1;
    do_cmd(2'b00, 1'b0, e, r, t);
    chk(e == 2'b10 && !started && !scl_low && !sda_low, "R7 rstart arb", e, 2);
    tgt_sda_low = 1'b0; repeat (4) @(negedge clk);

    // R6: written 1 overridden by target
    do_cmd(2'b00, 1'b0, e, r, t);
    tgt_sda_low = 1'b1;
    do_cmd(2'b10, 1'b1, e, r, t);
    chk(e == 2'b10 && !started && !scl_low && !sda_low, "R6 write arb", e, 2);
    tgt_sda_low = 1'b0; repeat (4) @(negedge clk);

    // R9: hold length swept across the limit
    seen_to = 1'b0;
    for (int h = (LIMIT - 2) * UNIT; h <= (LIMIT + 4) * UNIT; h++) begin
      do_cmd(2'b00, 1'b0, e, r, t);
      tgt_scl_low = 1'b1;
      fork begin repeat (h) @(negedge clk); tgt_scl_low = 1'b0; end join_none
      do_cmd(2'b10, 1'b0, e, r, t);
      chk(e == 2'b00 || e == 2'b01, "R9 code", e, 1);
      if (h <= (LIMIT - 1) * UNIT) chk(e == 2'b00, "R8 short hold", e, 0);
      if (h >= (LIMIT + 3) * UNIT) chk(e == 2'b01, "R9 long hold", e, 1);
      if (seen_to) chk(e == 2'b01, "R9 monotonic", e, 1);
      if (e == 2'b01) begin
        seen_to = 1'b1;
        chk(!started && !scl_low && !sda_low, "R9 auto stop", {started, scl_low, sda_low}, 0);
      end else begin
        do_cmd(2'b01, 1'b0, e, r, t);
      end
      while (tgt_scl_low) @(negedge clk);
      repeat (4) @(negedge clk);
    end
    chk(seen_to, "R9 seen", int'(seen_to), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule